// File: doc/BRIEF.md
# Late-Parity Checker with Held Error Flag

This block checks even parity over a registered data bus when the parity bit reaches it one or two clock cycles after the data it covers. Each clock, the block reduces the configured subset of data bits to a single parity bit and stores it in a short delay line. When the late parity bit arrives, it is combined with the stored value from the matching earlier cycle. The result is a registered partial-parity output and an active-low error flag.

Once an odd total is seen, the error flag stays low for a fixed number of cycles. Two checkers can be chained by wiring the partial-parity output of the first into the parity input of the second. The second one is then configured for the two-cycle lag. When both select inputs are high, the checker freezes and keeps its outputs and stored history.

Top module: `pchk_top`

## Requirements
- R1: While `rst` is high at a clock edge, `pp_out` becomes 0, `err_n` becomes 1 and the stored data parity is cleared. The first cycles after release therefore compare against all-zero history.
- R2: With `cfg_b` = 0 and the checker enabled, `pp_out` after an edge equals the parity of the covered bits captured at the previous enabled edge, XORed with `par_in` at this edge.
- R3: With `cfg_b` = 1, `pp_out` uses the covered-bit parity captured two enabled edges earlier, XORed with `par_in` at this edge.
- R4: `err_n` goes low after any enabled edge whose computed partial parity is 1. When the computed partial parity is 0 and no hold is running, `err_n` is 1.
- R5: After going low, `err_n` stays low for HOLD_CYC (default 2) cycles and then returns high unless a new error occurs.
- R6: A new error while the flag is held restarts the hold, so `err_n` stays low for HOLD_CYC cycles after the latest error.
- R7: When `chip_sel` and `aux_sel` are both 1 at an edge, `pp_out`, `err_n`, the hold count and the stored parity history all keep their values. The data at that edge is not captured.
- R8: When `chip_sel` is 0, or when `chip_sel` is 1 and `aux_sel` is 0, checking proceeds normally.
- R9: With `cfg_dup` = 0, the covered bits are bit numbers 2, 3, 5, 6 and 8 through 25. Bit number n is `data_in[n-1]`.
- R10: With `cfg_dup` = 1 and `cfg_b` = 0, the covered bits are 2, 3, 5, 6 and 8 through 14.
- R11: With `cfg_dup` = 1 and `cfg_b` = 1, the covered bits are 1 through 6, 8 through 10, 12 and 13.
- R12: Reset has priority over the select-based freeze, and it ends a running error hold at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dup | input | 1 | 1 selects a duplicated (narrow) arrangement for the bit subset |
| cfg_b | input | 1 | 1 selects arrangement B and a two-cycle parity lag |
| data_in | input | DATA_W | Registered data bus; bit number n on index n-1 |
| par_in | input | 1 | Late parity bit |
| chip_sel | input | 1 | Select input |
| aux_sel | input | 1 | Secondary select; both selects high freezes the checker |
| pp_out | output | 1 | Registered partial parity |
| err_n | output | 1 | Registered active-low error flag with hold |

## Verification
The assertions assume that `cfg_dup` and `cfg_b` change only while `rst` is high. A change during operation would mix history taken under two bit subsets. The bench therefore switches configuration only between reset pulses. It drives every input on the falling clock edge, so the inputs are stable at each rising edge. The random mix includes cycles with both selects high and occasional resets in the middle of a hold, while the model keeps its own parity history for the configured lag.

// File: rtl/pchk_pkg.sv
package pchk_pkg;

  // Coverage set for each configuration, bit number n on index n-1.
  function automatic logic [31:0] cover_mask(input logic dup, input logic arr_b);
    logic [31:0] m;
    m = '0;
    for (int n = 1; n <= 32; n++) begin
      if (!dup)
        m[n-1] = (n == 2) || (n == 3) || (n == 5) || (n == 6) || (n >= 8 && n <= 25);
      else if (!arr_b)
        m[n-1] = (n == 2) || (n == 3) || (n == 5) || (n == 6) || (n >= 8 && n <= 14);
      else
        m[n-1] = (n >= 1 && n <= 6) || (n >= 8 && n <= 10) || (n == 12) || (n == 13);
    end
    return m;
  endfunction

endpackage

// File: rtl/pchk_reduce.sv
module pchk_reduce #(
  parameter int DATA_W = 25
) (
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] mask,
  output logic              par
);
  logic [DATA_W-1:0] sel_bits;
  logic [DATA_W:0]   chain;

  assign sel_bits = data & mask;
  assign chain[0] = 1'b0;

  for (genvar i = 0; i < DATA_W; i++) begin : g_xor
    assign chain[i+1] = chain[i] ^ sel_bits[i];
  end

  assign par = chain[DATA_W];
endmodule

// File: rtl/pchk_align.sv
module pchk_align #(
  parameter int MAX_LAG = 2,
  localparam int IW = (MAX_LAG > 1) ? $clog2(MAX_LAG) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          din,
  input  logic [IW-1:0] lag_idx,
  output logic          tap
);
  logic [MAX_LAG-1:0] sr;

  for (genvar s = 0; s < MAX_LAG; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)
        sr[s] <= 1'b0;
      else if (en)
        sr[s] <= (s == 0) ? din : sr[(s == 0) ? 0 : s-1];
    end
  end

  assign tap = sr[lag_idx];

  assert_hist_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sr == '0));

  assert_hist_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(en) && !$past(rst)) |-> $stable(sr));
endmodule

// File: rtl/pchk_err_hold.sv
module pchk_err_hold #(
  parameter int HOLD_CYC = 2,
  localparam int CW = $clog2(HOLD_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic odd,
  output logic err_n
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_n <= 1'b1;
      cnt   <= '0;
    end else if (en) begin
      if (odd) begin
        err_n <= 1'b0;
        cnt   <= CW'(HOLD_CYC - 1);
      end else if (cnt != '0) begin
        cnt   <= cnt - 1'b1;
      end else begin
        err_n <= 1'b1;
      end
    end
  end

  assert_err_on_odd_R4: assert property (@(posedge clk) disable iff (rst)
    (en && odd) |=> !err_n);

  if (HOLD_CYC >= 2) begin : g_hold_chk
    assert_err_held_R5: assert property (@(posedge clk) disable iff (rst)
      $fell(err_n) |=> !err_n);
  end

  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(HOLD_CYC - 1));
endmodule

// File: rtl/pchk_top.sv
module pchk_top
  import pchk_pkg::*;
#(
  parameter int DATA_W   = 25,
  parameter int MAX_LAG  = 2,
  parameter int HOLD_CYC = 2,
  localparam int IW = (MAX_LAG > 1) ? $clog2(MAX_LAG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_dup,
  input  logic              cfg_b,
  input  logic [DATA_W-1:0] data_in,
  input  logic              par_in,
  input  logic              chip_sel,
  input  logic              aux_sel,
  output logic              pp_out,
  output logic              err_n
);
  logic              en;
  logic [31:0]       mask_full;
  logic [DATA_W-1:0] mask;
  logic              dpar;
  logic              tap;
  logic              pp_next;
  logic [IW-1:0]     lag_idx;

  assign en        = !(chip_sel && aux_sel);
  assign mask_full = cover_mask(cfg_dup, cfg_b);
  assign mask      = mask_full[DATA_W-1:0];
  assign lag_idx   = cfg_b ? IW'(MAX_LAG - 1) : '0;

  pchk_reduce #(.DATA_W(DATA_W)) u_reduce (
    .data (data_in),
    .mask (mask),
    .par  (dpar)
  );

  pchk_align #(.MAX_LAG(MAX_LAG)) u_align (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .din     (dpar),
    .lag_idx (lag_idx),
    .tap     (tap)
  );

  assign pp_next = tap ^ par_in;

  always_ff @(posedge clk) begin
    if (rst)
      pp_out <= 1'b0;
    else if (en)
      pp_out <= pp_next;
  end

  pchk_err_hold #(.HOLD_CYC(HOLD_CYC)) u_err (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .odd   (pp_next),
    .err_n (err_n)
  );

  assert_reset_vals_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pp_out && err_n));

  assert_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(chip_sel && aux_sel) && !$past(rst)) |-> ($stable(pp_out) && $stable(err_n)));

  assert_pp_implies_err_R4: assert property (@(posedge clk) disable iff (rst)
    pp_out |-> !err_n);
endmodule

// File: tb/pchk_top_bench.sv
module pchk_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_dup = 1'b0;
  logic        cfg_b = 1'b0;
  logic [24:0] data_in = '0;
  logic        par_in = 1'b0;
  logic        chip_sel = 1'b0;
  logic        aux_sel = 1'b0;
  logic        pp_out;
  logic        err_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // model state
  logic m_h0, m_h1, m_pp, m_err;
  int   m_cnt;

  always #4 clk = ~clk;

  pchk_top u_pchk_top (
    .clk(clk), .rst(rst), .cfg_dup(cfg_dup), .cfg_b(cfg_b),
    .data_in(data_in), .par_in(par_in), .chip_sel(chip_sel),
    .aux_sel(aux_sel), .pp_out(pp_out), .err_n(err_n)
  );

  function automatic bit covered(input logic dup, input logic b, input int n);
    if (!dup) return (n == 2 || n == 3 || n == 5 || n == 6 || n >= 8);
    if (!b)   return (n == 2 || n == 3 || n == 5 || n == 6 || (n >= 8 && n <= 14));
    return (n <= 6 || (n >= 8 && n <= 10) || n == 12 || n == 13);
  endfunction

  function automatic logic bpar(input logic [24:0] d);
    logic x = 1'b0;
    for (int n = 1; n <= 25; n++)
      if (covered(cfg_dup, cfg_b, n)) x ^= d[n-1];
    return x;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [24:0] d, input logic p, input logic cs,
                      input logic ax, input logic r, input string tag);
    logic t;
    data_in = d; par_in = p; chip_sel = cs; aux_sel = ax; rst = r;
    @(posedge clk);
    if (r) begin
      m_pp = 0; m_err = 1; m_h0 = 0; m_h1 = 0; m_cnt = 0;
    end else if (!(cs && ax)) begin
      t = cfg_b ? m_h1 : m_h0;
      m_pp = t ^ p;
      m_h1 = m_h0;
      m_h0 = bpar(d);
      if (m_pp) begin m_err = 0; m_cnt = 1; end
      else if (m_cnt != 0) m_cnt--;
      else m_err = 1;
    end
    @(negedge clk);
    check(tag, pp_out, m_pp, "pp_out");
    check(tag, err_n, m_err, "err_n");
  endtask

  task automatic set_cfg(input logic dup, input logic b);
    rst = 1'b1;
    cfg_dup = dup; cfg_b = b;
    step('0, 0, 0, 0, 1, "R1");
    step('0, 0, 0, 0, 1, "R1");
  endtask

  task automatic rand_run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [24:0] d;
      logic cs, ax, r;
      d  = 25'($urandom);
      cs = 1'($urandom);
      ax = 1'($urandom);
      r  = ($urandom % 40) == 0;
      step(d, 1'($urandom), cs, ax, r, r ? "R12" : tag);
    end
  endtask

  initial begin
    void'($urandom(32'd1357));
    @(negedge clk);

    // one-to-one, one-cycle lag
    set_cfg(0, 0);
    step('0, 0, 0, 0, 0, "R1");
    step('0, 0, 0, 0, 0, "R1");
    step(25'(1) << 24, 0, 0, 0, 0, "R9");   // bit 25 covered
    step('0, 0, 0, 0, 0, "R4");
    step('0, 0, 0, 0, 0, "R5");
    step('0, 0, 0, 0, 0, "R5");
    step(25'h41, 0, 0, 0, 0, "R9");          // bits 1 and 7 uncovered
    step('0, 0, 0, 0, 0, "R9");
    step(25'h2, 0, 0, 0, 0, "R6");
    step(25'h2, 0, 0, 0, 0, "R6");
    step('0, 0, 0, 0, 0, "R6");
    step('0, 0, 0, 0, 0, "R6");
    step('0, 0, 0, 0, 0, "R6");
    step(25'h2, 0, 1, 1, 0, "R7");           // frozen, not captured
    step('0, 0, 0, 0, 0, "R7");
    step(25'h2, 0, 1, 0, 0, "R8");
    step('0, 0, 0, 0, 0, "R8");
    step('0, 1, 1, 1, 0, "R7");              // error held while frozen
    step('0, 0, 1, 1, 0, "R7");
    step('0, 0, 1, 1, 1, "R12");
    step('0, 0, 0, 0, 0, "R12");
    step('0, 1, 0, 1, 0, "R8");
    rand_run(400, "R2");

    // arrangement A
    set_cfg(1, 0);
    step(25'h4000, 0, 0, 0, 0, "R10");       // bit 15 uncovered
    step('0, 0, 0, 0, 0, "R10");
    step(25'h2000, 0, 0, 0, 0, "R10");       // bit 14 covered
    step('0, 0, 0, 0, 0, "R10");
    rand_run(400, "R10");

    // arrangement B, two-cycle lag
    set_cfg(1, 1);
    step('0, 0, 0, 0, 0, "R1");
    step(25'h1, 0, 0, 0, 0, "R11");          // bit 1 covered
    step('0, 0, 0, 0, 0, "R3");
    step('0, 0, 0, 0, 0, "R3");
    step(25'h440, 0, 0, 0, 0, "R11");        // bits 7 and 11 uncovered
    step('0, 0, 0, 0, 0, "R11");
    step('0, 0, 0, 0, 0, "R11");
    step(25'h1, 1, 1, 1, 0, "R7");
    step('0, 0, 0, 0, 0, "R3");
    step('0, 0, 0, 0, 0, "R3");
    rand_run(400, "R3");

    // one-to-one, random with reset mid-hold
    set_cfg(0, 0);
    rand_run(300, "R2");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule